// File: doc/BRIEF.md
# Fractional-step programmable clock divider

This block derives a slower clock from a fast input clock. A 3-bit select input picks one of eight ratios, seven of them whole numbers and one of them 1.5. All timing inside the block is counted in input half-periods, so the 1.5 ratio is simply an output period of three half-periods. One part of the block works on the rising edge and one on the falling edge. Each part toggles a private flip-flop, and the two flip-flops are combined with an exclusive-OR so that an output edge can fall on either input edge.

A sequencer runs on the rising input edge and has three named states. `SEQ_INIT` holds after reset until the first rising edge arrives. `SEQ_LEAD` is a lead-in output period that stays low. `SEQ_RUN` is normal operation. The transitions are: reset to `SEQ_INIT` (asynchronous); `SEQ_INIT` to `SEQ_LEAD` when the lead-in period does not finish within the first input cycle; `SEQ_INIT` to `SEQ_RUN` when it does (ratio 1); `SEQ_LEAD` to `SEQ_RUN` when the lead-in phase count wraps; `SEQ_RUN` to `SEQ_RUN` otherwise. In every output period the high phase comes first. The select input is read only at a rising input edge that opens a new period, and the output is always low at that instant.

Top module: `frac_clk_div`

## Requirements
- R1: `ratio_sel` encoding (input periods per output period): 0 gives 1, 1 gives 1.5, 2 gives 2, 3 gives 3, 4 gives 4, 5 gives 6, 6 gives 8, 7 gives 12. Successive rising edges of `clk_div` are therefore 2, 3, 4, 6, 8, 12, 16 or 24 input half-periods apart.
- R2: At ratio 1.5, `clk_div` is high for two input half-periods and then low for one.
- R3: At ratios 1, 2, 4, 6, 8 and 12, `clk_div` is high for exactly half of each output period, and the high phase opens the period.
- R4: At ratio 3, `clk_div` is high for three input half-periods and low for three.
- R5: While `rst_n` is low, `clk_div` is low. Asserting reset forces the output low at once, without waiting for a clock edge.
- R6: After reset is released, `clk_div` stays low for one full output period of the selected ratio, counted from the first rising edge of `clk_in`. It then rises.
- R7: A new `ratio_sel` value takes effect only at a rising input edge that begins an output period, and the output is low at that instant. The period already in progress finishes with the old ratio. At ratio 1.5 only every second boundary falls on a rising edge, so only those boundaries accept a change.
- R8: A change on `ratio_sel` that is undone before the next accepting boundary has no effect on `clk_div`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 3 | Divide ratio select code |
| clk_div | output | 1 | Divided output clock |

## Verification
A wrong phase count or a wrongly held ratio shows up on `clk_div` within one output period. It appears as a level that is wrong in a particular input half-period, either the high phase placed wrongly or a period of the wrong length. To catch this, the bench samples the output once in every input half-period and compares it with a model built from the requirements. A select value latched at the wrong moment, or a lead-in state that does not end, is seen at the first boundary that follows. It appears as a rising edge that is early, late or missing, and as a measured period or high time that differs from what the code calls for.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    localparam int CODE_W   = 3;
    localparam int CODE_N   = 1 << CODE_W;
    // longest output period, in input half-periods
    localparam int HALF_MAX = 3 << ((CODE_N - 2) / 2);
    // room for phase + 2 before wrap
    localparam int HALF_W   = $clog2(HALF_MAX + 2) + 1;

    typedef enum logic [1:0] {
        SEQ_INIT = 2'd0,
        SEQ_LEAD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_t;

    // Even codes give powers of two; odd codes give three times a power of two
    function automatic logic [HALF_W-1:0] half_for_code(input logic [CODE_W-1:0] code);
        if (code[0])
            half_for_code = HALF_W'(3) << ((code - 1'b1) >> 1);
        else
            half_for_code = HALF_W'(2) << (code >> 1);
    endfunction

endpackage

// File: rtl/clkdiv_ratio_dec.sv
`timescale 1ns/1ps
module clkdiv_ratio_dec
    import clkdiv_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [HALF_W-1:0] half_len,
    output logic [HALF_W-1:0] high_len
);

    logic [HALF_W-1:0] len_tbl [CODE_N];

    for (genvar g = 0; g < CODE_N; g++) begin : g_len
        assign len_tbl[g] = half_for_code(CODE_W'(g));
    end

    assign half_len = len_tbl[code];
    // high phase: half the period, rounded up for odd half counts
    assign high_len = (half_len + 1'b1) >> 1;

endmodule

// File: rtl/clkdiv_seq.sv
`timescale 1ns/1ps
module clkdiv_seq
    import clkdiv_pkg::*;
(
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] new_half,
    input  logic [HALF_W-1:0] new_high,
    output logic              tgl_now,
    output logic              tgl_next,
    output seq_state_t        state_o,
    output logic [HALF_W-1:0] phase_o,
    output logic [HALF_W-1:0] period_o
);

    seq_state_t        state_q, state_d;
    logic [HALF_W-1:0] ph_q, ph_d;
    logic [HALF_W-1:0] half_q, high_q;
    logic [HALF_W-1:0] half_e, high_e;
    logic [HALF_W-1:0] slot_n, ph_plus2;
    logic              load_now, wrap;
    logic              lead_p, lead_n;
    logic              lvl_p, lvl_n, last_q;

    // ratio in force for the two half-slots handled at this rising edge
    always_comb begin
        load_now = (state_q == SEQ_INIT) || ((state_q == SEQ_RUN) && (ph_q == '0));
        half_e   = load_now ? new_half : half_q;
        high_e   = load_now ? new_high : high_q;
        ph_plus2 = ph_q + HALF_W'(2);
        wrap     = (ph_plus2 >= half_e);
        ph_d     = wrap ? (ph_plus2 - half_e) : ph_plus2;
        slot_n   = ((ph_q + 1'b1) == half_e) ? '0 : (ph_q + 1'b1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_INIT: state_d = wrap ? SEQ_RUN : SEQ_LEAD;
            SEQ_LEAD: state_d = wrap ? SEQ_RUN : SEQ_LEAD;
            SEQ_RUN:  state_d = SEQ_RUN;
            default:  state_d = SEQ_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_INIT;
            ph_q    <= '0;
            half_q  <= HALF_W'(2);
            high_q  <= HALF_W'(1);
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            half_q  <= half_e;
            high_q  <= high_e;
            last_q  <= lvl_n;
        end
    end

    // output decisions: wanted level of each half-slot, turned into toggle requests
    always_comb begin
        lead_p   = (state_q != SEQ_RUN);
        lead_n   = lead_p && (slot_n != '0);
        lvl_p    = !lead_p && (ph_q < high_e);
        lvl_n    = !lead_n && (slot_n < high_e);
        tgl_now  = lvl_p ^ last_q;
        tgl_next = lvl_n ^ lvl_p;
    end

    assign state_o  = state_q;
    assign phase_o  = ph_q;
    assign period_o = half_q;

endmodule

// File: rtl/clkdiv_edge_merge.sv
`timescale 1ns/1ps
module clkdiv_edge_merge (
    input  logic clk_in,
    input  logic rst_n,
    input  logic tgl_now,
    input  logic tgl_next,
    output logic clk_div
);

    logic rise_q, pend_q, fall_q;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            rise_q <= rise_q ^ tgl_now;
            pend_q <= tgl_next;
        end
    end

    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fall_q ^ pend_q;
    end

    assign clk_div = rise_q ^ fall_q;

endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div
    import clkdiv_pkg::*;
(
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_sel,
    output logic              clk_div
);

    logic [HALF_W-1:0] sel_half, sel_high;
    logic              tgl_now, tgl_next;
    seq_state_t        seq_state;
    logic [HALF_W-1:0] seq_phase, seq_period;

    clkdiv_ratio_dec i_dec (
        .code     (ratio_sel),
        .half_len (sel_half),
        .high_len (sel_high)
    );

    clkdiv_seq i_seq (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .new_half (sel_half),
        .new_high (sel_high),
        .tgl_now  (tgl_now),
        .tgl_next (tgl_next),
        .state_o  (seq_state),
        .phase_o  (seq_phase),
        .period_o (seq_period)
    );

    clkdiv_edge_merge i_merge (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .tgl_now  (tgl_now),
        .tgl_next (tgl_next),
        .clk_div  (clk_div)
    );

endmodule

// File: rtl/frac_clk_div_chk.sv
`timescale 1ns/1ps
module frac_clk_div_chk
    import clkdiv_pkg::*;
(
    input logic              clk_in,
    input logic              rst_n,
    input logic              clk_div,
    input seq_state_t        state,
    input logic [HALF_W-1:0] phase,
    input logic [HALF_W-1:0] period
);

    always @(negedge clk_in) begin
        if (!rst_n) begin
            p_reset_low_r5: assert (clk_div == 1'b0)
                else $error("output high during reset");
        end
    end

    p_lead_quiet_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state != SEQ_RUN) |-> !clk_div)
        else $error("output high before lead-in period ended");

    p_period_legal_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
        (period >= HALF_W'(2)) && (period <= HALF_W'(HALF_MAX)))
        else $error("held period outside the ratio set");

    p_phase_bound_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
        phase < period)
        else $error("phase beyond period length");

    p_load_on_boundary_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$stable(period) |-> ($past(phase) == '0))
        else $error("ratio changed away from a period boundary");

    p_low_at_boundary_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        ((state == SEQ_RUN) && (phase == '0)) |-> !clk_div)
        else $error("output high when a new ratio can be taken");

endmodule

bind frac_clk_div frac_clk_div_chk i_chk (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .clk_div (clk_div),
    .state   (seq_state),
    .phase   (seq_phase),
    .period  (seq_period)
);

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;

    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b1;
    logic [2:0] ratio_sel = 3'd0;
    logic       clk_div;

    always #10 clk_in = ~clk_in;   // 50 MHz

    frac_clk_div i_frac_clk_div (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .clk_div   (clk_div)
    );

    int    n_run = 0, n_fail = 0;
    bit    done = 0;
    // reference model state, in input half-slots
    int    m_half, m_pos, m_idx;
    bit    m_lead, m_started;
    int    prev_lvl, since_rise, hi_run, last_period, last_high;
    int    first_rise, watch_rise;
    string g_tag = "";

    // R1: half-periods per output period for each code
    function automatic int half_for(int c);
        int t [8];
        t = '{2, 3, 4, 6, 8, 12, 16, 24};
        return t[c];
    endfunction

    task automatic check(string tag, int got, int exp, string what);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic slot(bit is_pos);
        int    exp_lvl, got;
        string tag;
        if (!m_started) begin
            m_started = 1; m_lead = 1; m_pos = 0; m_idx = 0;
            m_half = half_for(int'(ratio_sel));
            first_rise = -1; hi_run = 0; since_rise = 0; prev_lvl = 0;
        end else begin
            m_idx++; m_pos++;
            if (m_pos == m_half) begin
                m_pos = 0; m_lead = 0;
                if (is_pos) m_half = half_for(int'(ratio_sel));   // R7
            end
        end
        exp_lvl = m_lead ? 0 : ((m_pos < (m_half + 1) / 2) ? 1 : 0);
        got = int'(clk_div);
        if (g_tag != "")       tag = g_tag;
        else if (m_lead)       tag = "R6";
        else if (m_half == 3)  tag = "R2";
        else if (m_half == 6)  tag = "R4";
        else                   tag = "R3";
        check(tag, got, exp_lvl, "half-slot level");
        since_rise++;
        if (got == 1 && prev_lvl == 0) begin
            last_period = since_rise; last_high = hi_run;
            since_rise = 0; hi_run = 0;
            if (first_rise < 0) first_rise = m_idx;
            if (watch_rise < 0) watch_rise = m_idx;
        end
        if (got == 1) hi_run++;
        prev_lvl = got;
    endtask

    task automatic run_cycle();
        @(posedge clk_in); #5; slot(1'b1);
        @(negedge clk_in); #5; slot(1'b0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R1 watchdog expired: got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        int exp_rise;
        void'($urandom(32'd4711));
        #2 rst_n = 1'b0;
        repeat (3) @(negedge clk_in);
        #5;
        check("R5", int'(clk_div), 0, "level while in reset");

        // R6: lead-in period with ratio 6 (12 half-slots)
        ratio_sel = 3'd5;
        rst_n = 1'b1; m_started = 0;
        repeat (20) run_cycle();
        check("R6", first_rise, 12, "first rise half-slot index");

        // R1..R4: each code held, period and high time measured
        for (int c = 0; c < 8; c++) begin
            ratio_sel = 3'(c);
            repeat (60) run_cycle();
            check("R1", last_period, half_for(c), "measured period");
            if (c == 1)      check("R2", last_high, 2, "high time at 1.5");
            else if (c == 3) check("R4", last_high, 3, "high time at 3");
            else             check("R3", last_high, half_for(c) / 2, "high time");
        end

        // R8: short excursion on the select input between boundaries
        ratio_sel = 3'd6;
        repeat (40) run_cycle();
        for (int g = 0; g < 40 && !(m_pos == 5 && m_half == 16); g++) run_cycle();
        g_tag = "R8";
        ratio_sel = 3'd0;
        repeat (2) run_cycle();
        ratio_sel = 3'd6;
        repeat (40) run_cycle();
        check("R8", last_period, 16, "period after reverted change");
        g_tag = "";

        // R7: change mid-period; old period must complete
        for (int g = 0; g < 40 && !(m_pos == 7 && m_half == 16); g++) run_cycle();
        exp_rise = m_idx + (16 - m_pos);
        watch_rise = -1;
        g_tag = "R7";
        ratio_sel = 3'd0;
        repeat (20) run_cycle();
        check("R7", watch_rise, exp_rise, "first rise after change");
        check("R7", last_period, 2, "period after change");
        // R7 at 1.5: change from 1.5 to 12 at an arbitrary point
        ratio_sel = 3'd1;
        repeat (10) run_cycle();
        ratio_sel = 3'd7;
        repeat (60) run_cycle();
        check("R7", last_period, 24, "period after leaving 1.5");
        g_tag = "";

        // R5: asynchronous reset in the middle of a high phase
        for (int g = 0; g < 200 && !(!m_lead && m_half == 24 && m_pos >= 2 && m_pos < 8); g++)
            run_cycle();
        #2 rst_n = 1'b0;
        #1 check("R5", int'(clk_div), 0, "level right after reset asserted");
        ratio_sel = 3'd1;
        @(negedge clk_in); #5;
        check("R5", int'(clk_div), 0, "level held in reset");
        rst_n = 1'b1; m_started = 0;
        repeat (10) run_cycle();
        check("R6", first_rise, 3, "first rise index at 1.5");

        // random select codes and hold times
        for (int k = 0; k < 150; k++) begin
            ratio_sel = 3'($urandom % 8);
            repeat (1 + ($urandom % 30)) run_cycle();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule